// File: doc/BRIEF.md
# Modem Handshake Change Detector

This block watches the four modem handshake pins of a serial port (clear-to-send, data-set-ready, ring indicator and carrier detect) and builds a nine-bit status word for the CPU. The pins are active low. The word holds the inverted level of each pin, four change flags that stay set once set, and the current flow-control mode flag. If any change flag is set, a modem-event interrupt request goes high. The interrupt controller that masks and merges this request is outside the block.

Every pin passes through its own synchroniser before edges are detected. Clear-to-send, data-set-ready and carrier detect set their change flag on a transition in either direction. The ring indicator flag is set only when the pin returns to its inactive level. The CPU reads the word while `statusRead` is high. At the clock edge that ends that cycle, every change flag clears. A change detected in that same cycle sets its flag again at that edge, so the event is not lost.

After reset, the synchroniser chain fills first. The first levels that reach the far end become the reference, and they raise no change.

Top module: `modem_change_detect`

## Requirements
- R1: Bits 7, 6, 5 and 4 of `statusWord` show the inverted synchronised level of the carrier-detect, ring, data-set-ready and clear-to-send pins, in that order. A pin change driven before clock edge k appears after edge k+1.
- R2: Bits 3, 1 and 0 of `statusWord` are the change flags of carrier detect, data-set-ready and clear-to-send. Each is set by a low-to-high or a high-to-low transition of its pin.
- R3: Bit 2 of `statusWord` is the ring-indicator change flag. It is set only by the ring pin going from 0 to 1, which is the inactive-going edge. A 1-to-0 transition leaves it at 0.
- R4: `modemIrq` is 1 exactly while at least one of bits 3:0 of `statusWord` is 1.
- R5: Bit 8 of `statusWord` follows `flowCtlMode` in the same cycle.
- R6: A change flag, once set, stays set until a read, even after its pin returns to the earlier level.
- R7: While `statusRead` is high, `statusWord` still shows the change flags. At the next rising edge all change flags clear, and `modemIrq` falls if no new change arrived.
- R8: A change detected in the cycle in which `statusRead` is high sets its flag at the clearing edge. The other flags clear at that edge.
- R9: After reset all change flags and `modemIrq` are 0. Pin levels held through reset, including active ones, become the baseline and set no flag.
- R10: A pin change driven before edge k sets its change flag after edge k+2, which is two synchroniser stages plus the flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctsPin | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsrPin | input | 1 | Data-set-ready pin, active low, asynchronous |
| riPin | input | 1 | Ring-indicator pin, active low, asynchronous |
| dcdPin | input | 1 | Carrier-detect pin, active low, asynchronous |
| flowCtlMode | input | 1 | Current flow-control mode setting |
| statusRead | input | 1 | High for one cycle when the CPU reads the status word |
| statusWord | output | 9 | Flow flag, inverted levels and change flags |
| modemIrq | output | 1 | Modem-event interrupt request |

## Verification
- **Level bits:** an inverted level is due two rising edges after the pin is driven.
- **Change flags and `modemIrq`:** these are due three edges after the pin is driven.
- **Read clearing:** the clear lands on the first edge after the read cycle.
- **Flow bit:** this is combinational and is due in the cycle it is driven.

The driver changes pins on falling edges and records each expectation with the exact cycle it is due. The monitor compares only in that cycle, one time step after the falling edge. A result that comes early or late fails, and so does a missed check. The case of a read in the same cycle as a change is placed so that the change event is present exactly during the read cycle.

// File: rtl/msd_pkg.sv
package msd_pkg;

  // Line order matches the bit order of both nibbles in the status word.
  localparam int unsigned LINE_COUNT = 4;
  localparam int unsigned IDX_CTS    = 0;
  localparam int unsigned IDX_DSR    = 1;
  localparam int unsigned IDX_RI     = 2;
  localparam int unsigned IDX_DCD    = 3;
  localparam int unsigned STATUS_W   = 2 * LINE_COUNT + 1;

  typedef logic [LINE_COUNT-1:0] lineVec_t;
  typedef logic [STATUS_W-1:0]   statusVec_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic armed;        // synchronisers filled, baseline valid
    logic clearSticky;  // read in progress, clear flags at next edge
  } ctrlStrobe_t;

endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/msd_ctrl.sv
module msd_ctrl
  import msd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        statusRead,
  output ctrlStrobe_t strobes
);

  // Synchroniser fill plus one cycle for the baseline register to load.
  localparam int unsigned WARM = SYNC_STAGES + 1;
  localparam int unsigned CW   = $clog2(WARM + 1);

  logic [CW-1:0] warmCnt;
  logic          armedNow;

  assign armedNow = (warmCnt == CW'(WARM));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
    end else if (!armedNow) begin
      warmCnt <= warmCnt + CW'(1);
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.armed       = armedNow;
    strobes.clearSticky = statusRead;
  end

  // Once armed, detection stays enabled until the next reset.
  p_armed_stays_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.armed |=> strobes.armed);

endmodule

// File: rtl/msd_datapath.sv
module msd_datapath
  import msd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  lineVec_t    pinVec,
  input  logic        flowCtlMode,
  input  ctrlStrobe_t strobes,
  output statusVec_t  statusWord,
  output logic        modemIrq
);

  lineVec_t syncVec;
  lineVec_t baseVec;
  lineVec_t evtVec;
  lineVec_t stickyQ;

  msd_sync #(
    .WIDTH    (LINE_COUNT),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL({LINE_COUNT{1'b1}})
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(pinVec),
    .syncOut(syncVec)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseVec <= '1;
    end else begin
      baseVec <= syncVec;
    end
  end

  // Per-line edge policy: ring indicator reacts to the inactive-going edge only.
  for (genvar g = 0; g < LINE_COUNT; g++) begin : g_edge
    if (g == IDX_RI) begin : g_trailing
      assign evtVec[g] = strobes.armed & ~baseVec[g] & syncVec[g];
    end else begin : g_any
      assign evtVec[g] = strobes.armed & (baseVec[g] ^ syncVec[g]);
    end
  end

  // Set wins over clear, so a change coinciding with a read survives.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ <= '0;
    end else begin
      stickyQ <= (stickyQ & ~{LINE_COUNT{strobes.clearSticky}}) | evtVec;
    end
  end

  assign statusWord = {flowCtlMode, ~syncVec, stickyQ};
  assign modemIrq   = |stickyQ;

  p_ri_trailing_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stickyQ[IDX_RI]) |-> ($past(baseVec[IDX_RI]) == 1'b0) && ($past(syncVec[IDX_RI]) == 1'b1));

  p_cts_change_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.armed && (syncVec[IDX_CTS] != baseVec[IDX_CTS])) |=> stickyQ[IDX_CTS]);

  p_hold_until_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearSticky |=> ((stickyQ & $past(stickyQ)) == $past(stickyQ)));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearSticky && (evtVec == '0)) |=> (stickyQ == '0));

  p_read_race_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearSticky |=> (stickyQ == $past(evtVec)));

  p_quiet_until_armed_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.armed |-> (stickyQ == '0));

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modemIrq) |-> ($past(evtVec) != '0));

endmodule

// File: rtl/modem_change_detect.sv
module modem_change_detect
  import msd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctsPin,
  input  logic       dsrPin,
  input  logic       riPin,
  input  logic       dcdPin,
  input  logic       flowCtlMode,
  input  logic       statusRead,
  output logic [8:0] statusWord,
  output logic       modemIrq
);

  lineVec_t    pinVec;
  ctrlStrobe_t strobes;

  always_comb begin
    pinVec          = '0;
    pinVec[IDX_CTS] = ctsPin;
    pinVec[IDX_DSR] = dsrPin;
    pinVec[IDX_RI]  = riPin;
    pinVec[IDX_DCD] = dcdPin;
  end

  msd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .statusRead(statusRead),
    .strobes   (strobes)
  );

  msd_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pinVec     (pinVec),
    .flowCtlMode(flowCtlMode),
    .strobes    (strobes),
    .statusWord (statusWord),
    .modemIrq   (modemIrq)
  );

endmodule

// File: tb/sim_modem_change_detect.sv
`timescale 1ns/1ps
module sim_modem_change_detect;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctsPin, dsrPin, riPin, dcdPin, flowCtlMode, statusRead;
  logic [8:0] statusWord;
  logic modemIrq;

  always #2.5 clk = ~clk;

  modem_change_detect u0 (
    .clk(clk), .rstN(rstN),
    .ctsPin(ctsPin), .dsrPin(dsrPin), .riPin(riPin), .dcdPin(dcdPin),
    .flowCtlMode(flowCtlMode), .statusRead(statusRead),
    .statusWord(statusWord), .modemIrq(modemIrq)
  );

  typedef struct {
    int         due;
    logic [9:0] mask;
    logic [9:0] val;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Observed vector: {irq, flow, dcdL, riL, dsrL, ctsL, dcdChg, riChg, dsrChg, ctsChg}
  task automatic expectIn(input int delay, input logic [9:0] mask,
                          input logic [9:0] val, input string tag);
    expItem_t it;
    it.due = cyc + delay; it.mask = mask; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doRead();
    statusRead = 1'b1;
    step(1);
    statusRead = 1'b0;
    expectIn(0, 10'h20F, 10'h000, "R7");
    step(1);
  endtask

  // Monitor: compare each expectation in the cycle it is due.
  always @(negedge clk) begin
    #1;
    while (expQ.size() > 0 && expQ[0].due <= cyc) begin
      expItem_t it;
      logic [9:0] obs;
      it = expQ.pop_front();
      obs = {modemIrq, statusWord};
      nChecks++;
      if (it.due != cyc || (obs & it.mask) != it.val) begin
        nFails++;
        $display("FAIL %s cycle %0d due %0d: actual %h expected %h (mask %h)",
                 it.tag, cyc, it.due, obs & it.mask, it.val, it.mask);
      end
    end
  end

  initial begin
    ctsPin = 1'b0; dsrPin = 1'b1; riPin = 1'b1; dcdPin = 1'b0;
    flowCtlMode = 1'b0; statusRead = 1'b0;
    step(3);
    rstN = 1'b1;
    step(6);
    // R9: active levels through reset are baseline, no flags, no irq
    expectIn(0, 10'h3FF, 10'h090, "R9");
    step(1);

    // R10/R1/R2: clear-to-send 0 -> 1
    ctsPin = 1'b1;
    expectIn(1, 10'h011, 10'h010, "R10");
    expectIn(2, 10'h011, 10'h000, "R1");
    expectIn(3, 10'h201, 10'h201, "R2");
    step(4);

    // R6: pin back to 0, flag stays
    ctsPin = 1'b0;
    expectIn(2, 10'h010, 10'h010, "R1");
    expectIn(5, 10'h201, 10'h201, "R6");
    step(6);

    // R7: flags visible during read, cleared after
    statusRead = 1'b1;
    expectIn(0, 10'h20F, 10'h201, "R7");
    step(1);
    statusRead = 1'b0;
    expectIn(0, 10'h20F, 10'h000, "R4");
    step(2);

    // R3: ring 1 -> 0 does not set flag, 0 -> 1 does
    riPin = 1'b0;
    expectIn(2, 10'h040, 10'h040, "R1");
    expectIn(4, 10'h204, 10'h000, "R3");
    step(5);
    riPin = 1'b1;
    expectIn(2, 10'h040, 10'h000, "R1");
    expectIn(3, 10'h204, 10'h204, "R3");
    step(4);
    doRead();

    // R2: data-set-ready both directions
    dsrPin = 1'b0;
    expectIn(3, 10'h222, 10'h222, "R2");
    step(4);
    doRead();
    dsrPin = 1'b1;
    expectIn(3, 10'h222, 10'h202, "R2");
    step(4);
    doRead();

    // R2: carrier detect 0 -> 1
    dcdPin = 1'b1;
    expectIn(3, 10'h288, 10'h208, "R2");
    step(4);

    // R8: data-set-ready event lands in the read cycle
    dsrPin = 1'b0;
    step(2);
    statusRead = 1'b1;
    expectIn(0, 10'h00F, 10'h008, "R8");
    step(1);
    statusRead = 1'b0;
    expectIn(0, 10'h20F, 10'h202, "R8");
    step(2);
    doRead();

    // R5: flow-control flag follows input at once
    flowCtlMode = 1'b1;
    expectIn(0, 10'h100, 10'h100, "R5");
    step(1);
    flowCtlMode = 1'b0;
    expectIn(0, 10'h100, 10'h000, "R5");
    step(3);

    while (expQ.size() > 0) step(1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule